// File: doc/BRIEF.md
# Three-wire serial memory command front-end

This block is the slave side of a three-wire serial memory port. The port has a chip select, a serial clock, a serial data input and a data output with an enable. Every pin is sampled on the system clock, and a rising serial clock edge counts only while chip select is high. The block waits for a start bit and then gathers a two-bit opcode, an address field and, where the command needs one, a data word. It decodes the four program commands and the two enable commands, and hands each one to a separate program sequencer. It serves reads itself through a one-cycle read port into an internal word array. A static organization pin selects 16-bit words or 8-bit bytes. A byte read fetches the containing 16-bit word and keeps one half of it.

Two streams leave the block. The command stream is valid/ready. `cmd_valid` rises only after a complete and exact frame ends with chip select falling. Op, address and data are then held unchanged until `cmd_ready` is sampled high. The serial side cannot be stalled. A frame that completes while an earlier command is still waiting is lost. If the waiting command is accepted in the very cycle a new one completes, the new one takes its place. The array read stream has no back-pressure: the array must return `rd_data` on the clock after `rd_en`. The serial clock half-period must be at least three system clocks.

Reads begin with one zero bit and then stream words MSB first. The address auto-increments and wraps until chip select drops. After a program command is issued, reselecting the block shows ready/busy status on the data output.

Top module: `mw_front`

## Requirements
- R1: After reset, `do_oe` and `cmd_valid` are low. `do_oe` is low whenever `cs` is low, and also after a read once `cs` has been dropped.
- R2: Zero bits sampled on `di` while idle are ignored. A frame starts at the first 1 sampled on a rising `sk` with `cs` high.
- R3: Opcode 10 (the two bits after the start bit) is a read. On the `sk` rise that samples the last address bit, DO is driven with a 0. Each following rise then shifts one word bit out, MSB first.
- R4: During a read, the next word follows the last bit of the previous one with no extra 0. The address increments each word and wraps from the top address to 0.
- R5: With `org_x16` low, the address field is one bit longer and words are 8 bits wide. Byte address a maps to array word a/2: its low half when a is even and its high half when a is odd. With `org_x16` high the address field is ADDR_W bits and words are 16 bits.
- R6: The most significant bit of the address field is clocked in but has no effect. In x16 mode `cmd_addr[ADDR_W-1]` is always 0.
- R7: Opcode 11 issues erase (`cmd_op`=1) with the address, and opcode 01 issues write (`cmd_op`=2) with address and data. A command issues only when `cs` falls after exactly the frame's bit count, and `cmd_data` is 0 for commands without a data word.
- R8: Opcode 00 decodes the top two address-field bits: 11 issues enable (`cmd_op`=5), 00 issues disable (6), 10 issues erase-all (3), and 01 issues write-all (4) with a data word. All four carry `cmd_addr`=0.
- R9: A frame cut short by `cs` falling, or followed by an extra `sk` rise before `cs` falls, issues nothing.
- R10: `cmd_op`/`cmd_addr`/`cmd_data` stay stable while `cmd_valid` is high and `cmd_ready` is low. A command completing while one is pending is dropped. A command completing in the cycle of acceptance replaces the accepted one.
- R11: After an erase, write, erase-all or write-all has been issued, `cs` high while idle drives DO with the inverse of `prog_busy`, until the next start bit. Enable and disable do not arm this status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| org_x16 | input | 1 | Organization: 1 selects 16-bit words, 0 selects bytes |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled on clk |
| di | input | 1 | Serial data in |
| do_out | output | 1 | Serial data out value |
| do_oe | output | 1 | Serial data out enable (0 means high impedance) |
| prog_busy | input | 1 | Program sequencer busy, reported as status |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | ADDR_W-1 | Array word address |
| rd_data | input | WORD_W | Array word, valid the clock after rd_en |
| cmd_valid | output | 1 | Decoded command valid |
| cmd_ready | input | 1 | Sequencer accepts the command |
| cmd_op | output | 3 | Command code (1 erase, 2 write, 3 erase-all, 4 write-all, 5 enable, 6 disable) |
| cmd_addr | output | ADDR_W | Command address (0 for global commands) |
| cmd_data | output | WORD_W | Command data word, zero-extended in byte mode |

## Verification
Two of this block's functions can land on one clock edge. One is completing a new command, when chip select falls after an exact frame. The other is the sequencer taking the command already waiting. The bench provokes this by dropping `cs` and raising `cmd_ready` on the same clock. It then requires the new command's fields on the output with `cmd_valid` still high. It contrasts this with the same frame arriving while `cmd_ready` stays low, where the old fields must survive. A read's dummy bit and first fetch share the address-complete edge, and this is judged by the first streamed word being intact.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ERASE = 3'd1,
    OP_WRITE = 3'd2,
    OP_ERAL  = 3'd3,
    OP_WRAL  = 3'd4,
    OP_EWEN  = 3'd5,
    OP_EWDS  = 3'd6
  } op_t;

  typedef enum logic [2:0] {
    F_IDLE, F_HDR, F_DATA, F_READ, F_ARMED, F_DROP
  } fst_t;
endpackage

// File: rtl/mw_pins.sv
module mw_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  output logic sk_rise,
  output logic cs_fall
);
  logic sk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
    end
  end

  assign sk_rise = cs & sk & ~sk_q;
  assign cs_fall = cs_q & ~cs;
endmodule

// File: rtl/mw_frame.sv
module mw_frame import mw_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              cs,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              di,
  output logic              rd_start,
  output logic [ADDR_W-1:0] rd_base,
  output logic              issue,
  output op_t               iss_op,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [WORD_W-1:0] iss_data,
  output logic              stat_en
);
  localparam int HW = ADDR_W + 3;
  localparam int CW = $clog2(HW + WORD_W);

  fst_t              state;
  logic [HW-2:0]     hdr;
  logic [HW-1:0]     nxt;
  logic [CW-1:0]     cnt, hdr_last, dat_last;
  logic [1:0]        opc, ext;
  logic [ADDR_W-1:0] eff;
  op_t               dec_op;
  logic              stat;

  assign hdr_last = wide ? CW'(ADDR_W + 1) : CW'(ADDR_W + 2);
  assign dat_last = wide ? CW'(WORD_W - 1) : CW'(WORD_W / 2 - 1);
  assign nxt      = {hdr, di};
  assign opc      = wide ? nxt[ADDR_W+1:ADDR_W] : nxt[ADDR_W+2:ADDR_W+1];
  assign ext      = wide ? nxt[ADDR_W-1:ADDR_W-2] : nxt[ADDR_W:ADDR_W-1];
  assign eff      = wide ? {1'b0, nxt[ADDR_W-2:0]} : nxt[ADDR_W-1:0];

  always_comb begin
    case (opc)
      2'b10:   dec_op = OP_NONE;
      2'b11:   dec_op = OP_ERASE;
      2'b01:   dec_op = OP_WRITE;
      default: begin
        case (ext)
          2'b11:   dec_op = OP_EWEN;
          2'b00:   dec_op = OP_EWDS;
          2'b10:   dec_op = OP_ERAL;
          default: dec_op = OP_WRAL;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= F_IDLE;
      hdr      <= '0;
      cnt      <= '0;
      rd_start <= 1'b0;
      rd_base  <= '0;
      iss_op   <= OP_NONE;
      iss_addr <= '0;
      iss_data <= '0;
      stat     <= 1'b0;
    end else begin
      rd_start <= 1'b0;
      if (issue && iss_op inside {OP_ERASE, OP_WRITE, OP_ERAL, OP_WRAL})
        stat <= 1'b1;
      if (!cs) begin
        state <= F_IDLE;
      end else if (sk_rise) begin
        case (state)
          F_IDLE: if (di) begin
            state <= F_HDR;
            cnt   <= '0;
            hdr   <= '0;
            stat  <= 1'b0;
          end
          F_HDR: begin
            hdr <= nxt[HW-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == hdr_last) begin
              cnt <= '0;
              if (opc == 2'b10) begin
                state    <= F_READ;
                rd_start <= 1'b1;
                rd_base  <= eff;
              end else begin
                iss_op   <= dec_op;
                iss_addr <= (dec_op == OP_ERASE || dec_op == OP_WRITE) ? eff : '0;
                iss_data <= '0;
                state    <= (dec_op == OP_WRITE || dec_op == OP_WRAL) ? F_DATA : F_ARMED;
              end
            end
          end
          F_DATA: begin
            iss_data <= {iss_data[WORD_W-2:0], di};
            cnt      <= cnt + 1'b1;
            if (cnt == dat_last) state <= F_ARMED;
          end
          F_ARMED: state <= F_DROP;
          default: ;
        endcase
      end
    end
  end

  assign issue   = cs_fall && (state == F_ARMED);
  assign stat_en = stat && (state == F_IDLE);
endmodule

// File: rtl/mw_reader.sv
module mw_reader #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              cs,
  input  logic              sk_rise,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-2:0] rd_addr,
  output logic              dbit,
  output logic              drive
);
  localparam int HB = WORD_W / 2;
  localparam int BW = $clog2(WORD_W);

  logic              load;
  logic [ADDR_W-1:0] acnt, anext;
  logic [ADDR_W-2:0] wnext;
  logic [WORD_W-1:0] sh;
  logic [BW-1:0]     bcnt, blast;
  logic [HB-1:0]     sel_byte;

  assign blast    = wide ? BW'(WORD_W - 1) : BW'(HB - 1);
  assign wnext    = acnt[ADDR_W-2:0] + 1'b1;
  assign anext    = wide ? {1'b0, wnext} : acnt + 1'b1;
  assign rd_addr  = wide ? acnt[ADDR_W-2:0] : acnt[ADDR_W-1:1];
  assign sel_byte = acnt[0] ? rd_data[WORD_W-1:HB] : rd_data[HB-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive <= 1'b0;
      rd_en <= 1'b0;
      load  <= 1'b0;
      acnt  <= '0;
      sh    <= '0;
      bcnt  <= '0;
      dbit  <= 1'b0;
    end else begin
      load  <= rd_en;
      rd_en <= 1'b0;
      if (load) sh <= wide ? rd_data : {sel_byte, {HB{1'b0}}};
      if (!cs) begin
        drive <= 1'b0;
      end else if (start) begin
        drive <= 1'b1;
        dbit  <= 1'b0;
        acnt  <= start_addr;
        bcnt  <= '0;
        rd_en <= 1'b1;
      end else if (drive && sk_rise) begin
        dbit <= sh[WORD_W-1];
        sh   <= {sh[WORD_W-2:0], 1'b0};
        if (bcnt == blast) begin
          bcnt  <= '0;
          acnt  <= anext;
          rd_en <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mw_cmd_port.sv
module mw_cmd_port import mw_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  op_t               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [WORD_W-1:0] in_data,
  input  logic              ready,
  output logic              valid,
  output logic [2:0]        op,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      op    <= 3'd0;
      addr  <= '0;
      data  <= '0;
    end else if (issue && (!valid || ready)) begin
      valid <= 1'b1;
      op    <= in_op;
      addr  <= in_addr;
      data  <= in_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mw_front.sv
module mw_front import mw_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              org_x16,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  output logic              do_out,
  output logic              do_oe,
  input  logic              prog_busy,
  output logic              rd_en,
  output logic [ADDR_W-2:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_data
);
  logic              sk_rise, cs_fall, rd_start, issue, stat_en, dbit, drive;
  logic [ADDR_W-1:0] rd_base, iss_addr;
  logic [WORD_W-1:0] iss_data;
  op_t               iss_op;

  mw_pins u_pins (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk),
    .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  mw_frame #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .wide(org_x16), .cs(cs), .sk_rise(sk_rise),
    .cs_fall(cs_fall), .di(di), .rd_start(rd_start), .rd_base(rd_base),
    .issue(issue), .iss_op(iss_op), .iss_addr(iss_addr), .iss_data(iss_data),
    .stat_en(stat_en)
  );

  mw_reader #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .wide(org_x16), .cs(cs), .sk_rise(sk_rise),
    .start(rd_start), .start_addr(rd_base), .rd_data(rd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .dbit(dbit), .drive(drive)
  );

  mw_cmd_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .issue(issue), .in_op(iss_op),
    .in_addr(iss_addr), .in_data(iss_data), .ready(cmd_ready),
    .valid(cmd_valid), .op(cmd_op), .addr(cmd_addr), .data(cmd_data)
  );

  assign do_oe  = cs & (drive | stat_en);
  assign do_out = do_oe & (drive ? dbit : ~prog_busy);
endmodule

// File: rtl/mw_front_chk.sv
module mw_front_chk import mw_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              org_x16,
  input logic              rd_en,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [WORD_W-1:0] cmd_data
);
  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_data));

  // R7
  cmd_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !$past(cs) && $past(cs, 2));

  // R4
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  // R8
  global_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_ERAL || cmd_op == OP_WRAL || cmd_op == OP_EWEN || cmd_op == OP_EWDS)
      |-> cmd_addr == '0);

  // R8
  legal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_op != OP_NONE && cmd_op <= OP_EWDS);

  // R6
  wide_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && org_x16 |-> !cmd_addr[ADDR_W-1]);
endmodule

bind mw_front mw_front_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .org_x16(org_x16), .rd_en(rd_en),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .cmd_data(cmd_data)
);

// File: tb/mw_front_test.sv
module mw_front_test;
  localparam int AW = 4;
  localparam int WW = 16;
  localparam int NW16 = 1 << (AW - 1);
  localparam int NB8 = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, org_x16, cs, sk, di, do_out, do_oe, prog_busy, rd_en;
  logic [AW-2:0] rd_addr;
  logic [WW-1:0] rd_data;
  logic cmd_valid, cmd_ready;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [WW-1:0] cmd_data;
  logic [WW-1:0] mem [NW16];
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  mw_front #(.ADDR_W(AW), .WORD_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs), .sk(sk), .di(di),
    .do_out(do_out), .do_oe(do_oe), .prog_busy(prog_busy), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs = 1'b1;
    tick(3);
  endtask

  task automatic desel();
    sk = 1'b0;
    cs = 1'b0;
    tick(4);
  endtask

  task automatic bitk(input logic b);
    di = b;
    sk = 1'b0;
    tick(4);
    sk = 1'b1;
    tick(4);
  endtask

  task automatic send_hdr(input bit wide, input logic [1:0] op, input logic [AW:0] field);
    int af;
    af = wide ? AW : AW + 1;
    bitk(1'b1);
    bitk(op[1]);
    bitk(op[0]);
    for (int i = af - 1; i >= 0; i--) bitk(field[i]);
  endtask

  task automatic send_data(input bit wide, input logic [WW-1:0] d);
    for (int i = (wide ? WW : WW / 2) - 1; i >= 0; i--) bitk(d[i]);
  endtask

  function automatic logic [WW-1:0] exp_word(input bit wide, input int a);
    logic [WW-1:0] w;
    if (wide) return mem[a % NW16];
    w = mem[(a % NB8) / 2];
    return (a % 2) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  function automatic logic [AW:0] mk_field(input bit wide, input logic msb, input int a);
    logic [AW-1:0] av;
    av = AW'(a);
    return wide ? {1'b0, msb, av[AW-2:0]} : {msb, av};
  endfunction

  task automatic do_read(input bit wide, input int a, input int nw, input int lead,
                         input logic msb, input string req);
    logic [WW-1:0] got;
    org_x16 = wide;
    tick(1);
    sel();
    for (int i = 0; i < lead; i++) bitk(1'b0);
    send_hdr(wide, 2'b10, mk_field(wide, msb, a));
    chk({req, " dummy zero"}, {30'd0, do_oe, do_out}, 32'd2);
    for (int w = 0; w < nw; w++) begin
      got = '0;
      for (int b = 0; b < (wide ? WW : WW / 2); b++) begin
        bitk(1'($urandom % 2));
        got = {got[WW-2:0], do_out};
      end
      chk(req, {16'd0, got}, {16'd0, exp_word(wide, a + w)});
    end
    desel();
    chk("R1 released after read", {31'd0, do_oe}, 32'd0);
  endtask

  task automatic prog(input bit wide, input logic [1:0] op, input logic [AW:0] field,
                      input bit has_data, input logic [WW-1:0] d);
    org_x16 = wide;
    tick(1);
    sel();
    send_hdr(wide, op, field);
    if (has_data) send_data(wide, d);
    desel();
  endtask

  task automatic expect_cmd(input string req, input logic [2:0] op, input logic [AW-1:0] a,
                            input logic [WW-1:0] d);
    chk({req, " valid"}, {31'd0, cmd_valid}, 32'd1);
    chk({req, " fields"}, {cmd_op, 9'd0, cmd_addr, cmd_data}, {op, 9'd0, a, d});
  endtask

  task automatic accept();
    cmd_ready = 1'b1;
    tick(1);
    cmd_ready = 1'b0;
    tick(1);
    chk("R10 valid clears on accept", {31'd0, cmd_valid}, 32'd0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7781));
    for (int i = 0; i < NW16; i++) mem[i] = 16'($urandom);
    rst_n = 1'b0; org_x16 = 1'b1; cs = 1'b0; sk = 1'b0; di = 1'b0;
    prog_busy = 1'b0; cmd_ready = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    chk("R1 reset outputs", {30'd0, do_oe, cmd_valid}, 32'd0);

    // R3 single word, R2 leading zeros, R4 wrap, R6 ignored MSB
    do_read(1'b1, 5, 1, 0, 1'b0, "R3 x16 read");
    do_read(1'b1, 2, 1, 3, 1'b0, "R2 leading zeros");
    do_read(1'b1, NW16 - 1, 3, 0, 1'b0, "R4 x16 stream wrap");
    do_read(1'b1, 3, 1, 0, 1'b1, "R6 msb ignored on read");
    // R5 byte organization and byte wrap
    do_read(1'b0, 4, 2, 0, 1'b0, "R5 x8 read");
    do_read(1'b0, NB8 - 1, 2, 0, 1'b1, "R5 x8 wrap");

    // R7 write and erase
    prog(1'b1, 2'b01, mk_field(1'b1, 1'b1, 6), 1'b1, 16'hA5C3);
    expect_cmd("R7 write x16", 3'd2, 4'd6, 16'hA5C3);
    accept();
    // R11 status after a program command
    prog_busy = 1'b1;
    sel();
    chk("R11 busy shown", {30'd0, do_oe, do_out}, 32'd2);
    prog_busy = 1'b0;
    tick(1);
    chk("R11 ready shown", {30'd0, do_oe, do_out}, 32'd3);
    bitk(1'b1);
    chk("R11 status ends at start bit", {31'd0, do_oe}, 32'd0);
    desel();
    chk("R9 aborted frame", {31'd0, cmd_valid}, 32'd0);

    prog(1'b0, 2'b11, mk_field(1'b0, 1'b1, 10), 1'b0, '0);
    expect_cmd("R7 erase x8", 3'd1, 4'd10, 16'd0);
    accept();

    // R8 extended commands
    prog(1'b1, 2'b00, 5'b0_1101, 1'b0, '0);
    expect_cmd("R8 enable", 3'd5, 4'd0, 16'd0);
    accept();
    sel();
    chk("R11 enable does not arm status", {31'd0, do_oe}, 32'd0);
    desel();
    prog(1'b1, 2'b00, 5'b0_0011, 1'b0, '0);
    expect_cmd("R8 disable", 3'd6, 4'd0, 16'd0);
    accept();
    prog(1'b0, 2'b00, 5'b10_110, 1'b0, '0);
    expect_cmd("R8 erase all x8", 3'd3, 4'd0, 16'd0);
    accept();
    prog(1'b1, 2'b00, 5'b0_0110, 1'b1, 16'h3C5A);
    expect_cmd("R8 write all x16", 3'd4, 4'd0, 16'h3C5A);
    accept();
    prog(1'b0, 2'b00, 5'b01_001, 1'b1, 16'h0096);
    expect_cmd("R8 write all x8", 3'd4, 4'd0, 16'h0096);
    accept();

    // R9 extra clock and short frames
    org_x16 = 1'b1;
    tick(1);
    sel();
    send_hdr(1'b1, 2'b11, mk_field(1'b1, 1'b0, 2));
    bitk(1'b0);
    desel();
    chk("R9 extra clock", {31'd0, cmd_valid}, 32'd0);
    sel();
    send_hdr(1'b1, 2'b01, mk_field(1'b1, 1'b0, 2));
    for (int i = 0; i < 15; i++) bitk(1'b1);
    desel();
    chk("R9 short data", {31'd0, cmd_valid}, 32'd0);

    // R10 pending command keeps its fields, new one dropped
    prog(1'b1, 2'b01, mk_field(1'b1, 1'b0, 1), 1'b1, 16'h1234);
    prog(1'b1, 2'b11, mk_field(1'b1, 1'b0, 4), 1'b0, '0);
    expect_cmd("R10 pending kept", 3'd2, 4'd1, 16'h1234);
    // R10 completion in the acceptance cycle replaces
    sel();
    send_hdr(1'b1, 2'b11, mk_field(1'b1, 1'b0, 7));
    sk = 1'b0;
    cs = 1'b0;
    cmd_ready = 1'b1;
    tick(1);
    cmd_ready = 1'b0;
    tick(3);
    expect_cmd("R10 same-cycle replace", 3'd1, 4'd7, 16'd0);
    accept();

    // random mix
    for (int it = 0; it < 40; it++) begin
      bit wide;
      int a;
      logic [WW-1:0] d;
      wide = 1'($urandom % 2);
      a = int'($urandom % NB8);
      d = 16'($urandom);
      if (!wide) d[15:8] = 8'h00;
      if ($urandom % 2) begin
        do_read(wide, wide ? a % NW16 : a, 1 + int'($urandom % 3), int'($urandom % 2),
                1'($urandom % 2), "R4 random read");
      end else begin
        prog(wide, 2'b01, mk_field(wide, 1'($urandom % 2), a), 1'b1, d);
        expect_cmd("R7 random write", 3'd2, wide ? AW'(a % NW16) : AW'(a), d);
        accept();
      end
    end

    summary();
    $finish;
  end
endmodule